// File: doc/BRIEF.md
# SPI Serial Clock Sequencer

This block produces the serial clock and chip select timing for a quad/standard SPI host from the peripheral clock. A 32-bit configuration word holds a clock divisor, a chip-select-to-first-edge delay, a phase bit and a polarity bit. A write-protect input can lock the word against writes.

A start pulse with a bit count launches a transfer. Chip select goes active, the set delay elapses, and the requested number of serial clock periods follow. The clock then returns to idle, chip select is released and a one-cycle done pulse is given.

Two one-cycle strobes, launch and capture, tell the data path where to change and where to sample data. Each strobe is high in the peripheral clock cycle just before the serial clock edge it belongs to. In memory mode the block always runs with phase 0 and polarity 0.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset the configuration reads as 0, cs_no is 1, sclk_o is 0, and done_o, launch_o and capture_o are 0.
- R2: Configuration bit fields are: delay in bits 23:16, divisor in bits 15:8, phase in bit 1 and polarity in bit 0. All other bits read as 0.
- R3: A write while wp_en_i is 1 leaves the configuration unchanged.
- R4: One serial clock period lasts divisor+1 peripheral cycles; a divisor of 0 runs as a period of 2. Each period starts with floor(P/2) cycles at the active level, followed by ceil(P/2) cycles at the idle level.
- R5: With a delay of 0, the first serial clock edge comes ceil(P/2) cycles after cs_no falls.
- R6: With a nonzero delay, the first serial clock edge comes that many cycles after cs_no falls.
- R7: With phase 0, capture_o comes before each leading edge and launch_o comes before each trailing edge except the last one. launch_o is also high in the start cycle. With phase 1, launch_o comes before each leading edge and capture_o before each trailing edge. Each strobe is high in the cycle before its edge.
- R8: sclk_o idles at the polarity bit; the active level is its inverse.
- R9: While mem_mode_i is 1, the block acts as phase 0 and polarity 0 whatever the stored bits hold.
- R10: A transfer of N bits (N from 1 to 256) gives exactly N periods. cs_no rises one full period after the last leading edge, and done_o is high for one cycle in that same cycle.
- R11: A start pulse is ignored while a transfer runs, and also when nbits_i is 0 or above 256.
- R12: A configuration write made during a transfer does not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| wp_en_i | input | 1 | Write protect; blocks configuration writes |
| mem_mode_i | input | 1 | Memory mode; forces phase 0 and polarity 0 |
| start_i | input | 1 | Transfer start pulse |
| nbits_i | input | 9 | Bit count for the transfer, 1 to 256 |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Data change strobe, one cycle before the edge |
| capture_o | output | 1 | Data sample strobe, one cycle before the edge |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench compares every cycle of a transfer against waveforms computed from the period, split and delay rules. It covers odd periods, where a wrong floor/ceil split would shift every trailing edge by one cycle, and a zero delay, where a design that waits zero cycles or a full period would misplace the first edge. It also covers a divisor of 0, where an unclamped counter would stall or run a one-cycle period, and a 256-bit transfer, where an off-by-one bit counter would add or drop a period. Finally it applies a mid-transfer configuration write and a mid-transfer start. A design that re-reads the live configuration would stretch the running clock, and one that accepts the second start would restart the sequence early.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  parameter int DIV_W   = 8;
  parameter int DLY_W   = 8;
  parameter int DIV_LSB = 8;
  parameter int DLY_LSB = 16;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
  } sck_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_ACT  = 2'd2,
    ST_REST = 2'd3
  } sck_st_e;
endpackage

// File: rtl/spi_sck_cfg.sv
module spi_sck_cfg
  import spi_sck_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        wp_en_i,
  output sck_cfg_t    cfg_o,
  output logic [31:0] rdata_o
);
  sck_cfg_t cfg_q;
  logic     unused_wdata;

  assign unused_wdata = ^{wdata_i[31:DLY_LSB+DLY_W], wdata_i[DIV_LSB-1:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && !wp_en_i) begin
      cfg_q.dly  <= wdata_i[DLY_LSB +: DLY_W];
      cfg_q.div  <= wdata_i[DIV_LSB +: DIV_W];
      cfg_q.cpha <= wdata_i[1];
      cfg_q.cpol <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[DLY_LSB +: DLY_W]   = cfg_q.dly;
    rdata_o[DIV_LSB +: DIV_W]   = cfg_q.div;
    rdata_o[1]                  = cfg_q.cpha;
    rdata_o[0]                  = cfg_q.cpol;
  end

  assign cfg_o = cfg_q;

  // R3
  wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/spi_sck_seq.sv
module spi_sck_seq
  import spi_sck_pkg::*;
#(
  parameter int MAX_BITS = 256,
  localparam int BITS_W  = $clog2(MAX_BITS) + 1,
  localparam int CNT_W   = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sck_cfg_t          cfg_i,
  input  logic              mem_mode_i,
  input  logic              start_i,
  input  logic [BITS_W-1:0] nbits_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              launch_o,
  output logic              capture_o,
  output logic              done_o
);
  sck_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q, act_q, rest_q;
  logic [CNT_W-1:0]  per_s, act_s, rest_s, dly_s;
  logic [BITS_W-1:0] bits_q;
  logic              cpha_q, cpol_q, done_q;
  logic              cpha_live, cpol_live, idle_s, cnt_end;
  logic              start_ok, lead_evt, trail_evt, last_trail, end_evt;

  // divisor 0 is clamped to a 2-cycle period
  assign per_s  = (cfg_i.div == '0) ? CNT_W'(2) : CNT_W'(cfg_i.div) + CNT_W'(1);
  assign act_s  = per_s >> 1;
  assign rest_s = per_s - act_s;
  assign dly_s  = (cfg_i.dly == '0) ? rest_s : CNT_W'(cfg_i.dly);

  assign cpha_live = cfg_i.cpha & ~mem_mode_i;
  assign cpol_live = cfg_i.cpol & ~mem_mode_i;

  assign idle_s     = (st_q == ST_IDLE);
  assign cnt_end    = (cnt_q == CNT_W'(1));
  assign start_ok   = idle_s && start_i && (nbits_i != '0) &&
                      (nbits_i <= BITS_W'(MAX_BITS));
  assign lead_evt   = cnt_end && ((st_q == ST_DLY) ||
                      ((st_q == ST_REST) && (bits_q != '0)));
  assign trail_evt  = cnt_end && (st_q == ST_ACT);
  assign last_trail = trail_evt && (bits_q == BITS_W'(1));
  assign end_evt    = cnt_end && (st_q == ST_REST) && (bits_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      act_q  <= '0;
      rest_q <= '0;
      bits_q <= '0;
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= end_evt;
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          st_q   <= ST_DLY;
          cnt_q  <= dly_s;
          act_q  <= act_s;
          rest_q <= rest_s;
          bits_q <= nbits_i;
          cpha_q <= cpha_live;
          cpol_q <= cpol_live;
        end
        ST_DLY: if (cnt_end) begin
          st_q  <= ST_ACT;
          cnt_q <= act_q;
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_ACT: if (cnt_end) begin
          st_q   <= ST_REST;
          cnt_q  <= rest_q;
          bits_q <= bits_q - BITS_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_REST: if (cnt_end) begin
          if (bits_q == '0) st_q <= ST_IDLE;
          else begin
            st_q  <= ST_ACT;
            cnt_q <= act_q;
          end
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = idle_s;
  assign done_o    = done_q;
  assign sclk_o    = (idle_s ? cpol_live : cpol_q) ^ (st_q == ST_ACT);
  assign capture_o = cpha_q ? trail_evt : lead_evt;
  assign launch_o  = (start_ok && !cpha_live) ||
                     (cpha_q ? lead_evt : (trail_evt && !last_trail));

  // R7
  capture_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !$stable(sclk_o));
  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_o && capture_o));
  // R10
  done_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(!cs_no)));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && start_i && !end_evt) |=> !cs_no);
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter int MAX_BITS = 256,
  localparam int BITS_W  = $clog2(MAX_BITS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              wp_en_i,
  input  logic              mem_mode_i,
  input  logic              start_i,
  input  logic [BITS_W-1:0] nbits_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              launch_o,
  output logic              capture_o,
  output logic              done_o
);
  sck_cfg_t cfg_s;

  spi_sck_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .wp_en_i (wp_en_i),
    .cfg_o   (cfg_s),
    .rdata_o (cfg_rdata_o)
  );

  spi_sck_seq #(.MAX_BITS(MAX_BITS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg_s),
    .mem_mode_i (mem_mode_i),
    .start_i    (start_i),
    .nbits_i    (nbits_i),
    .cs_no      (cs_no),
    .sclk_o     (sclk_o),
    .launch_o   (launch_o),
    .capture_o  (capture_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        wp_en_i = 1'b0;
  logic        mem_mode_i = 1'b0;
  logic        start_i = 1'b0;
  logic [8:0]  nbits_i = '0;
  logic        cs_no, sclk_o, launch_o, capture_o, done_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  spi_sck_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .wp_en_i(wp_en_i), .mem_mode_i(mem_mode_i),
    .start_i(start_i), .nbits_i(nbits_i), .cs_no(cs_no), .sclk_o(sclk_o),
    .launch_o(launch_o), .capture_o(capture_o), .done_o(done_o)
  );

  // vectors: divisor, delay, phase, polarity, memory mode, bit count
  localparam int NV = 7;
  localparam int V_DIV [NV] = '{3, 4, 2, 0, 5, 255, 1};
  localparam int V_DLY [NV] = '{0, 0, 5, 0, 3, 1, 0};
  localparam int V_PHA [NV] = '{0, 1, 0, 1, 1, 0, 0};
  localparam int V_POL [NV] = '{0, 0, 1, 1, 1, 0, 0};
  localparam int V_MEM [NV] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int V_N   [NV] = '{4, 3, 2, 5, 3, 2, 256};

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cfg_write(logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1;
    cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] pack(int dv, int dl, int ph, int po);
    return {8'h0, 8'(dl), 8'(dv), 6'h0, 1'(ph), 1'(po)};
  endfunction

  task automatic run(int v, bit mid_wr, bit mid_st, string tag);
    int p, a, d, n, tend, ph, idle;
    int e_sclk, e_cs, e_stb, e_done;
    p    = (V_DIV[v] == 0) ? 2 : V_DIV[v] + 1;
    a    = p / 2;
    d    = (V_DLY[v] == 0) ? p - a : V_DLY[v];
    n    = V_N[v];
    ph   = V_MEM[v] ? 0 : V_PHA[v];
    idle = V_MEM[v] ? 0 : V_POL[v];
    tend = d + n * p;
    e_sclk = 0; e_cs = 0; e_stb = 0; e_done = 0;
    cfg_write(pack(V_DIV[v], V_DLY[v], V_PHA[v], V_POL[v]));
    mem_mode_i = 1'(V_MEM[v]);
    @(negedge clk);
    start_i = 1'b1;
    nbits_i = 9'(n);
    for (int t = -1; t <= tend + 1; t++) begin
      bit act, lead_n, trail_n, exp_l, exp_c;
      int u;
      if (t >= 0) begin
        @(negedge clk);
        if (t == 0) start_i = 1'b0;
        if (t == 3 && mid_wr) begin cfg_we_i = 1'b1; cfg_wdata_i = 32'h000A_0702; end
        if (t == 4 && mid_wr) cfg_we_i = 1'b0;
        if (t == 3 && mid_st) begin start_i = 1'b1; nbits_i = 9'd1; end
        if (t == 4 && mid_st) start_i = 1'b0;
      end
      #1;
      u = t + 1;
      act     = (t >= d) && (t < tend) && (((t - d) % p) < a);
      lead_n  = (u >= d) && (u < tend) && (((u - d) % p) == 0);
      trail_n = (u >= d) && (u < tend) && (((u - d) % p) == a);
      if (ph == 1) begin
        exp_l = lead_n;
        exp_c = trail_n;
      end else begin
        exp_c = lead_n;
        exp_l = (t == -1) || (trail_n && ((u - d) / p < n - 1));
      end
      if (sclk_o !== 1'(idle ^ act)) e_sclk++;
      if (cs_no !== 1'(!(t >= 0 && t < tend))) e_cs++;
      if (launch_o !== exp_l || capture_o !== exp_c) e_stb++;
      if (done_o !== 1'(t == tend)) e_done++;
    end
    chk(e_sclk == 0, tag, $sformatf("vec %0d sclk mismatching cycles", v), e_sclk, 0);
    chk(e_cs == 0, "R10", $sformatf("vec %0d cs_no mismatching cycles", v), e_cs, 0);
    chk(e_stb == 0, "R7", $sformatf("vec %0d strobe mismatching cycles", v), e_stb, 0);
    chk(e_done == 0, "R10", $sformatf("vec %0d done mismatching cycles", v), e_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata_o == 32'h0, "R1", "cfg after reset", cfg_rdata_o, 0);
    chk({cs_no, sclk_o, done_o, launch_o, capture_o} == 5'b10000, "R1", "outputs after reset",
        {cs_no, sclk_o, done_o, launch_o, capture_o}, 5'b10000);
    // R2 layout and unused bits
    cfg_write(32'hFFFF_FFFF);
    #1 chk(cfg_rdata_o == 32'h00FF_FF03, "R2", "readback all ones", cfg_rdata_o, 32'h00FF_FF03);
    cfg_write(32'h0012_3402);
    #1 chk(cfg_rdata_o == 32'h0012_3402, "R2", "readback fields", cfg_rdata_o, 32'h0012_3402);
    // R3 write protect
    wp_en_i = 1'b1;
    cfg_write(32'h0000_0001);
    #1 chk(cfg_rdata_o == 32'h0012_3402, "R3", "write blocked", cfg_rdata_o, 32'h0012_3402);
    wp_en_i = 1'b0;
    // R8 / R9 idle level
    cfg_write(32'h0000_0001);
    #1 chk(sclk_o == 1'b1, "R8", "idle high with polarity 1", sclk_o, 1);
    mem_mode_i = 1'b1;
    #1 chk(sclk_o == 1'b0, "R9", "memory mode forces idle low", sclk_o, 0);
    mem_mode_i = 1'b0;

    for (int v = 0; v < NV; v++)
      run(v, 1'b0, 1'b0, (V_MEM[v] != 0) ? "R9" : "R4 R5 R6 R8");

    // R12 write during transfer
    run(0, 1'b1, 1'b0, "R12");
    #1 chk(cfg_rdata_o == 32'h000A_0702, "R12", "write applied after run", cfg_rdata_o, 32'h000A_0702);
    // R11 start while busy
    run(1, 1'b0, 1'b1, "R11");
    // R11 out-of-range counts
    @(negedge clk);
    start_i = 1'b1;
    nbits_i = 9'd0;
    @(negedge clk);
    nbits_i = 9'd257;
    @(negedge clk);
    start_i = 1'b0;
    #1 chk(cs_no == 1'b1 && done_o == 1'b0, "R11", "count 0 and 257 ignored", {cs_no, done_o}, 2'b10);
    repeat (4) @(negedge clk);
    #1 chk(cs_no == 1'b1, "R11", "still idle later", cs_no, 1);

    summary();
    $finish;
  end
endmodule